// File: doc/BRIEF.md
# Coalescing Store Queue with Read-Miss Bypass

This block sits between a write-through cache and main memory. Each store the cache sends is taken into a small queue, so the processor never has to wait for memory. When a store's block address matches an entry that is waiting behind the oldest one, the store is folded into that entry instead of taking a new slot. Each slot holds one line-aligned block: a block address, one data word per word position, and a valid bit per word. The oldest slot is offered to memory as a masked block write. Slots leave in the order they were allocated, one per memory handshake.

A read that misses in the cache asks the queue before going to memory. A policy input selects one of two behaviours. In bypass mode the lookup completes in the same cycle. When a buffered slot holds the requested word, the lookup returns that word, taken from the youngest slot that has it. In safe mode the lookup completes only once the queue is empty, and it never returns data. Addresses are word addresses. The low bits select the word inside a block and the remaining bits form the block address.

Top module: `merge_wbuf`

## Requirements
- R1: After a synchronous active-low reset the queue is empty: `mem_valid` is 0 and `st_ready` is 1, and the number of occupied slots never exceeds DEPTH.
- R2: A store to a block not held in any mergeable slot takes a new slot. When that slot drains, `mem_addr` carries the block address (`st_addr` without its low log2(WORDS) bits). `mem_mask` has only bit w set, where w is the word index (the low bits of `st_addr`). Word w of `mem_data` is in bits [w*DW +: DW].
- R3: A store whose block matches a slot other than the oldest writes its word into the youngest such slot and sets that word's mask bit. No new slot is used.
- R4: A second store to the same word of a mergeable slot replaces the earlier data.
- R5: The oldest slot is the one offered to memory, and it takes no merges. While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_mask` and `mem_data` stay stable. A store to the oldest slot's block takes a new slot instead.
- R6: Slots drain in allocation order. Each cycle with `mem_valid` and `mem_ready` both 1 drains exactly one slot.
- R7: When all DEPTH slots are occupied, `st_ready` is 0 for a store with no mergeable match and 1 for a store that can merge. A stalled store is taken once a slot drains.
- R8: With `fwd_mode`=1, `rd_done` equals `rd_req` in the same cycle. `rd_hit` is 1 only if a slot holds the requested block with that word's valid bit set, and `rd_data` then gives that word.
- R9: If several slots hold the requested word, `rd_data` comes from the youngest of them.
- R10: With `fwd_mode`=0, `rd_done` is 1 only while the queue is empty, and `rd_hit` stays 0.
- R11: A store taken at a clock edge is visible to lookups from the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fwd_mode | input | 1 | 1: lookups bypass from the queue; 0: lookups wait for an empty queue |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store taken at the edge when st_valid is also 1 |
| rd_req | input | 1 | Read-miss lookup request |
| rd_addr | input | AW | Lookup word address |
| rd_done | output | 1 | Lookup completes this cycle |
| rd_hit | output | 1 | Requested word found in the queue |
| rd_data | output | DW | Bypassed word, zero when there is no hit |
| mem_valid | output | 1 | Oldest slot offered to memory |
| mem_ready | input | 1 | Memory takes the offered slot |
| mem_addr | output | AW-log2(WORDS) | Block address of the offered slot |
| mem_data | output | WORDS*DW | Block data, word w in bits [w*DW +: DW] |
| mem_mask | output | WORDS | Per-word valid mask of the offered slot |

## Verification
The hardest states to reach are a full queue with the oldest slot held at the memory port, and a word that is present in several slots at once. To build them, the stimulus keeps `mem_ready` low while it issues stores to a repeated block, stores to a new block, and a store that overwrites a word already written. It then issues a merging store and a non-matching store against the full queue. After that it releases memory and compares every drained block, in order, against a queue of expected writes.

// File: rtl/wbuf_pkg.sv
// Shared defaults and types for the coalescing store queue.
package wbuf_pkg;
    localparam int WB_DEPTH = 4;   // slots, power of two
    localparam int WB_WORDS = 4;   // words per block, power of two
    localparam int WB_DW    = 32;  // word width
    localparam int WB_AW    = 16;  // word address width

    typedef enum logic {
        POL_SAFE   = 1'b0,
        POL_BYPASS = 1'b1
    } rd_policy_e;
endpackage

// File: rtl/wbuf_store.sv
// Slot storage kept as a circular queue. It takes stores, either merging them
// into the youngest matching slot other than the oldest or allocating at the
// tail, and offers the oldest slot to memory.
// Assumes: DEPTH is a power of two so the pointers wrap naturally.
module wbuf_store #(
    parameter int DEPTH = wbuf_pkg::WB_DEPTH,
    parameter int WORDS = wbuf_pkg::WB_WORDS,
    parameter int DW    = wbuf_pkg::WB_DW,
    parameter int BW    = 14,
    localparam int PW   = $clog2(DEPTH),
    localparam int OW   = $clog2(WORDS),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              st_valid,
    input  logic [BW-1:0]                     st_blk,
    input  logic [OW-1:0]                     st_off,
    input  logic [DW-1:0]                     st_data,
    output logic                              st_ready,
    output logic                              mem_valid,
    input  logic                              mem_ready,
    output logic [BW-1:0]                     mem_addr,
    output logic [WORDS-1:0][DW-1:0]          mem_data,
    output logic [WORDS-1:0]                  mem_mask,
    output logic [DEPTH-1:0][BW-1:0]          blk_q,
    output logic [DEPTH-1:0][WORDS-1:0]       vld_q,
    output logic [DEPTH-1:0][WORDS-1:0][DW-1:0] dat_q,
    output logic [PW-1:0]                     head_q,
    output logic [CW-1:0]                     cnt_q
);
    logic          mhit;
    logic [PW-1:0] mpos;
    logic [PW-1:0] scan;
    logic [PW-1:0] tail;
    logic          st_fire;
    logic          pop;

    // Find the youngest matching slot, skipping the oldest one (it is draining).
    always_comb begin
        mhit = 1'b0;
        mpos = head_q;
        scan = head_q;
        for (int k = 1; k < DEPTH; k++) begin
            scan = head_q + PW'(k);
            if (CW'(k) < cnt_q && blk_q[scan] == st_blk) begin
                mhit = 1'b1;
                mpos = scan;
            end
        end
    end

    // Handshake terms at both edges of the queue.
    always_comb begin
        tail      = head_q + PW'(cnt_q);
        st_ready  = mhit || (cnt_q != CW'(DEPTH));
        st_fire   = st_valid && st_ready;
        mem_valid = (cnt_q != '0);
        pop       = mem_valid && mem_ready;
        mem_addr  = blk_q[head_q];
        mem_data  = dat_q[head_q];
        mem_mask  = vld_q[head_q];
    end

    // Slot contents: merge a word into a slot or fill a fresh one.
    always_ff @(posedge clk) begin
        if (st_fire) begin
            if (mhit) begin
                dat_q[mpos][st_off] <= st_data;
                vld_q[mpos][st_off] <= 1'b1;
            end else begin
                blk_q[tail]         <= st_blk;
                vld_q[tail]         <= WORDS'(1) << st_off;
                dat_q[tail][st_off] <= st_data;
            end
        end
    end

    // Head pointer and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop) head_q <= head_q + PW'(1);
            cnt_q <= cnt_q + CW'(st_fire && !mhit) - CW'(pop);
        end
    end
endmodule

// File: rtl/wbuf_fwd.sv
// Read-miss lookup. In bypass mode it returns the requested word from the
// youngest slot that holds it. In safe mode it completes only when the queue
// is empty. Purely combinational over the registered slot state.
module wbuf_fwd #(
    parameter int DEPTH = wbuf_pkg::WB_DEPTH,
    parameter int WORDS = wbuf_pkg::WB_WORDS,
    parameter int DW    = wbuf_pkg::WB_DW,
    parameter int BW    = 14,
    localparam int PW   = $clog2(DEPTH),
    localparam int OW   = $clog2(WORDS),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                                fwd_mode,
    input  logic                                rd_req,
    input  logic [BW-1:0]                       rd_blk,
    input  logic [OW-1:0]                       rd_off,
    input  logic [DEPTH-1:0][BW-1:0]            blk_q,
    input  logic [DEPTH-1:0][WORDS-1:0]         vld_q,
    input  logic [DEPTH-1:0][WORDS-1:0][DW-1:0] dat_q,
    input  logic [PW-1:0]                       head_q,
    input  logic [CW-1:0]                       cnt_q,
    output logic                                rd_done,
    output logic                                rd_hit,
    output logic [DW-1:0]                       rd_data
);
    wbuf_pkg::rd_policy_e pol;
    logic          found;
    logic [DW-1:0] word;
    logic [PW-1:0] scan;

    // Walk the slots from oldest to youngest; the last match wins.
    always_comb begin
        found = 1'b0;
        word  = '0;
        scan  = head_q;
        for (int k = 0; k < DEPTH; k++) begin
            scan = head_q + PW'(k);
            if (CW'(k) < cnt_q && blk_q[scan] == rd_blk && vld_q[scan][rd_off]) begin
                found = 1'b1;
                word  = dat_q[scan][rd_off];
            end
        end
    end

    // Apply the read policy.
    always_comb begin
        pol     = wbuf_pkg::rd_policy_e'(fwd_mode);
        rd_hit  = rd_req && (pol == wbuf_pkg::POL_BYPASS) && found;
        rd_data = rd_hit ? word : '0;
        rd_done = rd_req && ((pol == wbuf_pkg::POL_BYPASS) || (cnt_q == '0));
    end
endmodule

// File: rtl/merge_wbuf.sv
// Coalescing store queue for a write-through cache, with read-miss bypass.
// Splits word addresses into block and word index and connects the slot
// storage to the lookup path.
// Assumes: DEPTH and WORDS are powers of two, AW > log2(WORDS).
module merge_wbuf #(
    parameter int DEPTH = wbuf_pkg::WB_DEPTH,
    parameter int WORDS = wbuf_pkg::WB_WORDS,
    parameter int DW    = wbuf_pkg::WB_DW,
    parameter int AW    = wbuf_pkg::WB_AW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fwd_mode,
    input  logic                         st_valid,
    input  logic [AW-1:0]                st_addr,
    input  logic [DW-1:0]                st_data,
    output logic                         st_ready,
    input  logic                         rd_req,
    input  logic [AW-1:0]                rd_addr,
    output logic                         rd_done,
    output logic                         rd_hit,
    output logic [DW-1:0]                rd_data,
    output logic                         mem_valid,
    input  logic                         mem_ready,
    output logic [AW-$clog2(WORDS)-1:0]  mem_addr,
    output logic [WORDS*DW-1:0]          mem_data,
    output logic [WORDS-1:0]             mem_mask
);
    localparam int OW = $clog2(WORDS);
    localparam int BW = AW - OW;
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][BW-1:0]            blk_q;
    logic [DEPTH-1:0][WORDS-1:0]         vld_q;
    logic [DEPTH-1:0][WORDS-1:0][DW-1:0] dat_q;
    logic [PW-1:0]                       head_q;
    logic [CW-1:0]                       cnt_q;
    logic [WORDS-1:0][DW-1:0]            mem_words;

    // Present the oldest slot's words as one flat bus.
    assign mem_data = mem_words;

    wbuf_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .st_blk    (st_addr[AW-1:OW]),
        .st_off    (st_addr[OW-1:0]),
        .st_data   (st_data),
        .st_ready  (st_ready),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_words),
        .mem_mask  (mem_mask),
        .blk_q     (blk_q),
        .vld_q     (vld_q),
        .dat_q     (dat_q),
        .head_q    (head_q),
        .cnt_q     (cnt_q)
    );

    wbuf_fwd #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_fwd (
        .fwd_mode (fwd_mode),
        .rd_req   (rd_req),
        .rd_blk   (rd_addr[AW-1:OW]),
        .rd_off   (rd_addr[OW-1:0]),
        .blk_q    (blk_q),
        .vld_q    (vld_q),
        .dat_q    (dat_q),
        .head_q   (head_q),
        .cnt_q    (cnt_q),
        .rd_done  (rd_done),
        .rd_hit   (rd_hit),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/wbuf_chk.sv
// Property checker for merge_wbuf, attached with bind. Watches the store,
// lookup and memory ports together with the occupancy count.
module wbuf_chk #(
    parameter int DEPTH = 4,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int BW    = 14,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                fwd_mode,
    input logic                st_valid,
    input logic                st_ready,
    input logic                rd_req,
    input logic                rd_done,
    input logic                rd_hit,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [BW-1:0]       mem_addr,
    input logic [WORDS*DW-1:0] mem_data,
    input logic [WORDS-1:0]    mem_mask,
    input logic [CW-1:0]       cnt
);
    // R1
    cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> (cnt == CW'(DEPTH)));

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_mask) && $stable(mem_data)));

    // R10
    safe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwd_mode && rd_done) |-> !mem_valid);

    // R10
    safe_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_mode |-> !rd_hit);

    // R8
    bypass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_mode && rd_req) |-> rd_done);
endmodule

bind merge_wbuf wbuf_chk #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_mode  (fwd_mode),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .rd_req    (rd_req),
    .rd_done   (rd_done),
    .rd_hit    (rd_hit),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_mask  (mem_mask),
    .cnt       (cnt_q)
);

// File: tb/merge_wbuf_test.sv
// Scoreboard bench: the stimulus pushes expected memory writes into a queue,
// and a monitor pops and compares them as the design drains.
module merge_wbuf_test;
    localparam int AW = 16, DW = 32, WORDS = 4, BW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_mode = 1'b1;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready;
    logic rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic rd_done, rd_hit;
    logic [DW-1:0] rd_data;
    logic mem_valid;
    logic mem_ready = 1'b0;
    logic [BW-1:0] mem_addr;
    logic [WORDS*DW-1:0] mem_data;
    logic [WORDS-1:0] mem_mask;

    typedef struct {
        logic [BW-1:0]       a;
        logic [WORDS-1:0]    m;
        logic [WORDS*DW-1:0] d;
    } exp_t;
    exp_t sbq[$];

    int ntest = 0, nfail = 0, drains = 0;
    bit done = 1'b0;

    merge_wbuf uut (
        .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_mask(mem_mask)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        ntest++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [BW-1:0] a, input logic [WORDS-1:0] m,
                             input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                             input logic [DW-1:0] w2, input logic [DW-1:0] w3);
        exp_t e;
        e.a = a; e.m = m; e.d = {w3, w2, w1, w0};
        sbq.push_back(e);
    endtask

    // Present a store until it is taken; count cycles spent stalled.
    task automatic st(input logic [BW-1:0] b, input int off, input logic [DW-1:0] d, output int waited);
        waited = 0;
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = {b, 2'(off)}; st_data = d;
        forever begin
            @(negedge clk);
            if (st_ready) break;
            waited++;
        end
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic rd(input logic [BW-1:0] b, input int off,
                      output logic dn, output logic ht, output logic [DW-1:0] dt);
        @(posedge clk); #1;
        rd_req = 1'b1; rd_addr = {b, 2'(off)};
        @(negedge clk);
        dn = rd_done; ht = rd_hit; dt = rd_data;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    // Monitor: compare each drained block against the scoreboard (R2, R6).
    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            drains++;
            if (sbq.size() == 0) begin
                chk(1'b0, "R6 unexpected drain", 128'(mem_addr), 128'(0));
            end else begin
                exp_t e;
                bit ok;
                e = sbq.pop_front();
                ok = (mem_addr == e.a) && (mem_mask == e.m);
                for (int w = 0; w < WORDS; w++)
                    if (e.m[w] && mem_data[w*DW +: DW] != e.d[w*DW +: DW]) ok = 1'b0;
                chk(ok, "R2/R3/R6 drained block", {mem_addr, mem_mask, mem_data[59:0]},
                    {e.a, e.m, e.d[59:0]});
            end
        end
    end

    task automatic wait_drain;
        for (int i = 0; i < 100 && (sbq.size() != 0 || mem_valid); i++) @(negedge clk);
    endtask

    initial begin
        int wt;
        logic dn, ht;
        logic [DW-1:0] dt;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(mem_valid == 1'b0, "R1 mem_valid after reset", 128'(mem_valid), 128'(0));
        chk(st_ready == 1'b1, "R1 st_ready after reset", 128'(st_ready), 128'(1));

        // Bypass mode, memory held off to build up the queue.
        st(14'h10, 0, 32'h11, wt);              // slot A (oldest)
        rd(14'h10, 0, dn, ht, dt);              // R11
        chk(dn && ht && dt == 32'h11, "R11 next-cycle visibility", {dn, ht, dt}, {1'b1, 1'b1, 32'h11});
        chk(mem_addr == 14'h10 && mem_mask == 4'b0001, "R2 offered block", {mem_addr, mem_mask}, {14'h10, 4'b0001});
        st(14'h10, 1, 32'h22, wt);              // R5: new slot B, oldest not merged
        chk(mem_mask == 4'b0001, "R5 oldest mask untouched", 128'(mem_mask), 128'(4'b0001));
        st(14'h10, 1, 32'h33, wt);              // R4: overwrite in B
        st(14'h20, 2, 32'h44, wt);              // slot C
        st(14'h10, 0, 32'h55, wt);              // R3: merge into B
        rd(14'h10, 0, dn, ht, dt);
        chk(ht && dt == 32'h55, "R9 youngest copy wins", {ht, dt}, {1'b1, 32'h55});
        rd(14'h10, 1, dn, ht, dt);
        chk(ht && dt == 32'h33, "R4 latest data", {ht, dt}, {1'b1, 32'h33});
        rd(14'h10, 3, dn, ht, dt);
        chk(dn && !ht && dt == 0, "R8 invalid word misses", {dn, ht, dt}, {1'b1, 1'b0, 32'h0});
        rd(14'h33, 0, dn, ht, dt);
        chk(dn && !ht, "R8 unknown block misses", {dn, ht}, {1'b1, 1'b0});
        rd(14'h20, 2, dn, ht, dt);
        chk(ht && dt == 32'h44, "R8 bypass hit", {ht, dt}, {1'b1, 32'h44});
        st(14'h30, 3, 32'h66, wt);              // slot D, queue full
        st(14'h20, 0, 32'h77, wt);              // merge while full
        chk(wt == 0, "R7 merge accepted when full", 128'(wt), 128'(0));
        rd(14'h20, 0, dn, ht, dt);
        chk(ht && dt == 32'h77, "R3 merged word visible", {ht, dt}, {1'b1, 32'h77});
        chk(mem_valid && mem_addr == 14'h10 && mem_mask == 4'b0001 && mem_data[31:0] == 32'h11,
            "R5 oldest held", {mem_addr, mem_mask}, {14'h10, 4'b0001});

        expect_wr(14'h10, 4'b0001, 32'h11, 0, 0, 0);
        expect_wr(14'h10, 4'b0011, 32'h55, 32'h33, 0, 0);
        expect_wr(14'h20, 4'b0101, 32'h77, 0, 32'h44, 0);
        expect_wr(14'h30, 4'b1000, 0, 0, 0, 32'h66);
        expect_wr(14'h40, 4'b0010, 0, 32'h88, 0, 0);
        fork
            st(14'h40, 1, 32'h88, wt);
            begin
                repeat (3) @(negedge clk);
                chk(st_ready == 1'b0, "R7 full with no match stalls", 128'(st_ready), 128'(0));
                @(posedge clk); #1 mem_ready = 1'b1;
            end
        join
        chk(wt >= 3, "R7 stalled store waited", 128'(wt), 128'(3));
        wait_drain();
        chk(drains == 5 && sbq.size() == 0, "R6 drain count", 128'(drains), 128'(5));
        rd(14'h10, 0, dn, ht, dt);
        chk(dn && !ht, "R8 empty queue misses", {dn, ht}, {1'b1, 1'b0});

        // Safe mode: lookups wait for an empty queue.
        @(posedge clk); #1 mem_ready = 1'b0; fwd_mode = 1'b0;
        st(14'h50, 0, 32'h99, wt);
        expect_wr(14'h50, 4'b0001, 32'h99, 0, 0, 0);
        rd(14'h50, 0, dn, ht, dt);
        chk(!dn && !ht, "R10 waits while queue busy", {dn, ht}, {1'b0, 1'b0});
        @(posedge clk); #1 mem_ready = 1'b1;
        wait_drain();
        rd(14'h50, 0, dn, ht, dt);
        chk(dn && !ht, "R10 completes when empty, no data", {dn, ht}, {1'b1, 1'b0});
        chk(drains == 6, "R6 total drains", 128'(drains), 128'(6));

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            ntest++; nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", ntest, nfail);
            $finish;
        end
    end
endmodule